// File: doc/BRIEF.md
# Overwrite-Oldest Byte Ring Buffer

This block is a byte queue of parameterised depth, intended as the receive or transmit store behind a UART-style register front end. The producer side never stalls. A push into a queue that still has room appends the byte. A push into a full queue drops the oldest byte so the newest one fits, and the occupancy stays at the depth. The consumer reads the head byte on `popData` in the same cycle that it asserts `popEn`. The pop takes effect at the next clock edge. When the queue is empty, `popData` shows all ones and a pop does nothing.

The depth may be any value of two or more. Pointer wrap is therefore an explicit compare against the last index and does not rely on truncating a power of two. Occupancy and the empty and full flags are outputs. A synchronous reset empties the queue.

Top module: `ovw_ring_buffer`

## Requirements
- R1: During and after synchronous reset (`rst` high at a rising edge), `count` is 0, `isEmpty` is 1, `isFull` is 0 and `popData` is 0xFF.
- R2: A push (`pushEn`=1, `popEn`=0) while `count` is below DEPTH stores `pushData` and raises `count` by one at the next edge.
- R3: `popData` combinationally shows the oldest stored byte while the queue is non-empty. A pop (`popEn`=1, `pushEn`=0) lowers `count` by one and exposes the next byte, so bytes leave in push order.
- R4: A push alone while `count` equals DEPTH drops the oldest byte and appends the new one. `count` stays at DEPTH, and the queue then holds the newest DEPTH bytes in order.
- R5: While the queue is empty, `popData` is 0xFF. A pop alone leaves `count` and the stored contents unchanged.
- R6: A push and a pop in the same cycle on a queue that is neither empty nor full returns the head byte, appends the new byte and leaves `count` unchanged.
- R7: A push and a pop in the same cycle on an empty queue returns 0xFF, stores the pushed byte and makes `count` 1.
- R8: A push and a pop in the same cycle on a full queue returns the oldest byte, appends the new one and leaves `count` at DEPTH.
- R9: `isEmpty` is 1 exactly when `count` is 0, and `isFull` is 1 exactly when `count` equals DEPTH.
- R10: Read and write positions wrap correctly for a depth that is not a power of two (default DEPTH=5) across long mixed push and pop sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, empties the queue |
| pushEn | input | 1 | Push strobe, always accepted |
| pushData | input | DATA_W | Byte to push |
| popEn | input | 1 | Pop strobe |
| popData | output | DATA_W | Head byte, or all ones when empty |
| count | output | $clog2(DEPTH+1) | Number of stored bytes |
| isEmpty | output | 1 | Queue holds no byte |
| isFull | output | 1 | Queue holds DEPTH bytes |

## Verification
`popData` is a combinational function of the current state, so it is due in the same cycle as the pop request, before the edge that consumes the byte. `count`, `isEmpty` and `isFull` change one edge after a push or a pop. The bench drives inputs on the falling edge and compares every output a moment later against a queue model. That model is updated only at the following rising edge, so each comparison sees the state left by the previous edge, which is exactly what the design shows at that time.

// File: rtl/rb_pkg.sv
package rb_pkg;

  // Strobes the control passes to the storage datapath
  typedef struct packed {
    logic wrEn;      // write pushData at the write position
    logic bufEmpty;  // no valid head byte
  } rbStrobe_t;

endpackage

// File: rtl/rb_ctrl.sv
module rb_ctrl
  import rb_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pushEn,
  input  logic          popEn,
  output rbStrobe_t     st,
  output logic [PW-1:0] wrPtr,
  output logic [PW-1:0] rdPtr,
  output logic [CW-1:0] count,
  output logic          isEmpty,
  output logic          isFull
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

  logic popValid, rdAdv, cntUp, cntDn;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    isEmpty  = (count == '0);
    isFull   = (count == FULLCNT);
    popValid = popEn && !isEmpty;
    // head moves on a real pop, or when a lone push displaces the oldest byte
    rdAdv    = popValid || (pushEn && isFull && !popEn);
    cntUp    = pushEn && (!isFull || popValid);
    cntDn    = popValid;
    st.wrEn     = pushEn;
    st.bufEmpty = isEmpty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushEn) wrPtr <= nextPtr(wrPtr);
      if (rdAdv)  rdPtr <= nextPtr(rdPtr);
      if (cntUp && !cntDn)      count <= count + 1'b1;
      else if (cntDn && !cntUp) count <= count - 1'b1;
    end
  end

  // distance from read to write position, used only by the checks below
  int ptrGap;
  always_comb ptrGap = (int'(wrPtr) + DEPTH - int'(rdPtr)) % DEPTH;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= FULLCNT); // R9
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(wrPtr) < DEPTH) && (int'(rdPtr) < DEPTH)); // R10
  AST_PTR_GAP: assert property (@(posedge clk) disable iff (rst)
    isFull ? (ptrGap == 0) : (ptrGap == int'(count))); // R10
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (isFull && pushEn) |=> isFull); // R4
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (isEmpty && popEn && !pushEn) |=> (isEmpty && $stable(rdPtr))); // R5
  AST_MID_BOTH: assert property (@(posedge clk) disable iff (rst)
    (pushEn && popEn && !isEmpty && !isFull) |=> $stable(count)); // R6
  AST_EMPTY_BOTH: assert property (@(posedge clk) disable iff (rst)
    (pushEn && popEn && isEmpty) |=> (count == CW'(1))); // R7

endmodule

// File: rtl/rb_datapath.sv
module rb_datapath
  import rb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 5,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  rbStrobe_t         st,
  input  logic [PW-1:0]     wrPtr,
  input  logic [PW-1:0]     rdPtr,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (st.wrEn) mem[wrPtr] <= pushData;
  end

  always_comb popData = st.bufEmpty ? {DATA_W{1'b1}} : mem[rdPtr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    st.wrEn |=> (mem[$past(wrPtr)] == $past(pushData))); // R2

endmodule

// File: rtl/ovw_ring_buffer.sv
module ovw_ring_buffer
  import rb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pushEn,
  input  logic [DATA_W-1:0]          pushData,
  input  logic                       popEn,
  output logic [DATA_W-1:0]          popData,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       isEmpty,
  output logic                       isFull
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rbStrobe_t     st;
  logic [PW-1:0] wrPtr, rdPtr;

  rb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .pushEn(pushEn), .popEn(popEn),
    .st(st), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .count(count), .isEmpty(isEmpty), .isFull(isFull)
  );

  rb_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .st(st), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .pushData(pushData), .popData(popData)
  );

  initial begin
    AST_DEPTH_MIN: assert (DEPTH >= 2); // R10
  end

endmodule

// File: tb/ovw_ring_buffer_test.sv
module ovw_ring_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 5;
  localparam int DW = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1, pushEn = 0, popEn = 0;
  logic [DW-1:0] pushData = '0;
  logic [DW-1:0] popData;
  logic [CW-1:0] count;
  logic isEmpty, isFull;

  ovw_ring_buffer #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .pushEn(pushEn), .pushData(pushData),
    .popEn(popEn), .popData(popData), .count(count),
    .isEmpty(isEmpty), .isFull(isFull)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;
  bit done = 0;
  byte unsigned model[$];

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive on falling edge, compare before the rising edge, update model at it
  task automatic step(input bit ps, input byte unsigned d, input bit pp, input string tag);
    int expData;
    @(negedge clk);
    pushEn = ps; pushData = d; popEn = pp;
    #1;
    expData = (model.size() > 0) ? model[0] : 8'hFF;
    check({tag, " popData"}, popData, expData);
    check({tag, " count"}, count, model.size());
    check({"R9 isEmpty ", tag}, isEmpty, model.size() == 0);
    check({"R9 isFull ", tag}, isFull, model.size() == DEPTH);
    @(posedge clk);
    if (pp && model.size() > 0) void'(model.pop_front());
    if (ps) begin
      if (model.size() == DEPTH) void'(model.pop_front());
      model.push_back(d);
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    // R1: reset, including a push held during reset
    pushEn = 1; pushData = 8'h11;
    repeat (2) @(posedge clk);
    @(negedge clk);
    pushEn = 0; rst = 0;
    #1;
    check("R1 count", count, 0);
    check("R1 isEmpty", isEmpty, 1);
    check("R1 isFull", isFull, 0);
    check("R1 popData", popData, 8'hFF);

    for (int i = 0; i < 3; i++) step(1, 8'hA0 + i, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, 8'h00, 1, "R3");
    step(0, 8'h00, 1, "R5");
    step(0, 8'h00, 1, "R5");
    step(0, 8'h00, 0, "R5");
    for (int i = 0; i < 8; i++) step(1, 8'h30 + i, 0, "R4");
    for (int i = 0; i < 3; i++) step(1, 8'h50 + i, 1, "R8");
    step(0, 8'h00, 1, "R3");
    step(0, 8'h00, 1, "R3");
    for (int i = 0; i < 4; i++) step(1, 8'h70 + i, 1, "R6");
    for (int i = 0; i < 4; i++) step(0, 8'h00, 1, "R3");
    step(1, 8'hC5, 1, "R7");
    step(0, 8'h00, 1, "R7");
    step(0, 8'h00, 0, "R7");
    for (int i = 0; i < 400; i++)
      step(($urandom % 3) != 0, 8'($urandom), ($urandom % 2) == 0, "R10");
    for (int i = 0; i < 7; i++) step(0, 8'h00, 1, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule